// File: doc/BRIEF.md
# Flag-Driven Character I/O Port

This block is the character input/output port of a small accumulator machine. It holds one input byte and one output byte. Two flags show whether each side is ready. An input flag is raised when a new character has arrived and is waiting to be read. An output flag is raised when the output device can accept a new character. The devices set these flags through a valid/ready handshake, and the CPU's I/O instructions clear them. Software polls readiness with skip-on-flag instructions. It never reads a status word.

The CPU side works in the cycle in which the sequencer executes an I/O-class instruction. In that cycle the CPU raises a strobe and presents six instruction bits and the low byte of the accumulator. Each instruction bit selects one action, and several may be set together. In the same cycle the port answers with:
- a replacement accumulator low byte and its write enable,
- a skip request for the program counter,
- a done pulse that clears the sequence counter.

An interrupt-enable flip-flop can be set and cleared. Interrupt servicing is not part of this block.

Top module: `io_port`

## Requirements
- R1: After reset the input flag is 0 (`inReady`=1), the output flag is 1 (`outValid`=0), the output register is 0 and `intEnable`=0.
- R2: `inReady` is the inverse of the input flag. A cycle with `inValid`=1 and `inReady`=1 captures `inData` into the input register and sets the input flag at that clock edge.
- R3: While the input flag is 1, `inData` and `inValid` have no effect. A later read returns the byte captured first.
- R4: Read (strobe with `irBits[5]`, instruction bit 11) drives `acLowWe`=1 and `acLowNew` = input register in the strobe cycle, and clears the input flag at that edge. If a device load happens in the same cycle, the load wins.
- R5: Write (strobe with `irBits[4]`, instruction bit 10) loads `acLow` into the output register and clears the output flag. From the next cycle `outData` shows the byte and `outValid`=1.
- R6: A cycle with `outValid`=1 and `outReady`=1 sets the output flag. If a write strobe arrives in the same cycle, the write wins and `outValid` stays 1.
- R7: `skipReq` is high in the strobe cycle when `irBits[3]` (instruction bit 9) is set and the input flag is 1, or when `irBits[2]` (instruction bit 8) is set and the output flag is 1. Otherwise it is low.
- R8: `irBits[1]` (instruction bit 7) sets `intEnable` and `irBits[0]` (instruction bit 6) clears it. When both are set, clear wins.
- R9: `seqClear` equals the strobe. Without a strobe, `acLowWe`, `skipReq` and `seqClear` are 0, and `outData` and `intEnable` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioStrobe | input | 1 | I/O instruction executing this cycle |
| irBits | input | 6 | Instruction bits 11 down to 6 |
| acLow | input | 8 | Accumulator low byte |
| acLowNew | output | 8 | Replacement accumulator low byte |
| acLowWe | output | 1 | Write enable for acLowNew |
| skipReq | output | 1 | Request to skip the next instruction |
| seqClear | output | 1 | Instruction done, clear sequence counter |
| inData | input | 8 | Character from input device |
| inValid | input | 1 | Input device offers a character |
| inReady | output | 1 | Port can take a character |
| outData | output | 8 | Character for output device |
| outValid | output | 1 | Output character pending |
| outReady | input | 1 | Output device takes the character |
| intEnable | output | 1 | Interrupt-enable flip-flop |

## Verification
A wrong flag shows up at the ports within one cycle. A stuck or inverted input flag changes `inReady` and makes a skip-on-input test answer wrongly in the same strobe cycle. A lost output-flag update is visible on `outValid` on the next cycle. A corrupted input register stays hidden until the next read instruction. The bench therefore reads after every burst of device offers, so that an overwritten or lost byte appears on `acLowNew`. Collisions are covered on purpose:
- a write together with an accept,
- a read together with a device load,
- set and clear of the interrupt enable together.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int DATA_W = 8;
  localparam int IRB_W  = 6;
  localparam int B_INP  = 5;
  localparam int B_OUT  = 4;
  localparam int B_SKI  = 3;
  localparam int B_SKO  = 2;
  localparam int B_IEON = 1;
  localparam int B_IEOF = 0;

  typedef struct packed {
    logic loadIn;
    logic doInp;
    logic doOut;
    logic acceptOut;
    logic setIen;
    logic clrIen;
  } ioStrobes_t;
endpackage

// File: rtl/io_port_ctrl.sv
module io_port_ctrl
  import io_port_pkg::*;
(
  input  logic             ioStrobe,
  input  logic [IRB_W-1:0] irBits,
  input  logic             inValid,
  input  logic             outReady,
  input  logic             fgi,
  input  logic             fgo,
  output ioStrobes_t       stb,
  output logic             inReady,
  output logic             outValid,
  output logic             acLowWe,
  output logic             skipReq,
  output logic             seqClear
);
  always_comb begin
    inReady       = ~fgi;
    outValid      = ~fgo;
    stb.loadIn    = inValid & ~fgi;
    stb.acceptOut = outReady & ~fgo;
    stb.doInp     = ioStrobe & irBits[B_INP];
    stb.doOut     = ioStrobe & irBits[B_OUT];
    stb.setIen    = ioStrobe & irBits[B_IEON];
    stb.clrIen    = ioStrobe & irBits[B_IEOF];
    acLowWe       = stb.doInp;
    skipReq       = ioStrobe & ((irBits[B_SKI] & fgi) | (irBits[B_SKO] & fgo));
    seqClear      = ioStrobe;
  end
endmodule

// File: rtl/io_port_dp.sv
module io_port_dp
  import io_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobes_t        stb,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] acLow,
  output logic [DATA_W-1:0] inByte,
  output logic [DATA_W-1:0] outByte,
  output logic              fgi,
  output logic              fgo,
  output logic              ien
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inByte  <= '0;
      outByte <= '0;
      fgi     <= 1'b0;
      fgo     <= 1'b1;
      ien     <= 1'b0;
    end else begin
      if (stb.loadIn) inByte <= inData;
      if (stb.loadIn)     fgi <= 1'b1;
      else if (stb.doInp) fgi <= 1'b0;
      if (stb.doOut) begin
        outByte <= acLow;
        fgo     <= 1'b0;
      end else if (stb.acceptOut) begin
        fgo     <= 1'b1;
      end
      if (stb.clrIen)      ien <= 1'b0;
      else if (stb.setIen) ien <= 1'b1;
    end
  end
endmodule

// File: rtl/io_port.sv
module io_port
  import io_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioStrobe,
  input  logic [IRB_W-1:0]  irBits,
  input  logic [DATA_W-1:0] acLow,
  output logic [DATA_W-1:0] acLowNew,
  output logic              acLowWe,
  output logic              skipReq,
  output logic              seqClear,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              intEnable
);
  ioStrobes_t        stb;
  logic              fgi, fgo;
  logic [DATA_W-1:0] inByte;

  io_port_ctrl u_ctrl (
    .ioStrobe(ioStrobe), .irBits(irBits), .inValid(inValid),
    .outReady(outReady), .fgi(fgi), .fgo(fgo), .stb(stb),
    .inReady(inReady), .outValid(outValid), .acLowWe(acLowWe),
    .skipReq(skipReq), .seqClear(seqClear)
  );

  io_port_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .acLow(acLow),
    .inByte(inByte), .outByte(outData), .fgi(fgi), .fgo(fgo), .ien(intEnable)
  );

  assign acLowNew = inByte;
endmodule

// File: rtl/io_port_checker.sv
module io_port_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ioStrobe,
  input logic [5:0] irBits,
  input logic [7:0] acLow,
  input logic       acLowWe,
  input logic       skipReq,
  input logic       seqClear,
  input logic       inValid,
  input logic       inReady,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady,
  input logic       intEnable
);
  // R2: an accepted offer closes the input side on the next cycle
  a_r2_load_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady);
  // R4: a read with no pending offer reopens the input side
  a_r4_read_clears_flag: assert property (@(posedge clk) disable iff (!rstN)
    ioStrobe && irBits[5] && !inValid |=> inReady);
  // R5: write publishes the accumulator byte
  a_r5_write_publishes: assert property (@(posedge clk) disable iff (!rstN)
    ioStrobe && irBits[4] |=> outValid && outData == $past(acLow));
  // R6: an accept without a write ends the pending state
  a_r6_accept_drops_valid: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !(ioStrobe && irBits[4]) |=> !outValid);
  // R7: a skip only happens inside an instruction
  a_r7_skip_in_strobe: assert property (@(posedge clk) disable iff (!rstN)
    skipReq |-> seqClear);
  // R8: clear has priority over set
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    ioStrobe && irBits[0] |=> !intEnable);
  a_r8_set_only: assert property (@(posedge clk) disable iff (!rstN)
    ioStrobe && irBits[1] && !irBits[0] |=> intEnable);
  // R9: idle cycles keep state and raise no CPU response
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ioStrobe |-> !acLowWe && !skipReq && !seqClear);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ioStrobe |=> $stable(outData) && $stable(intEnable));
endmodule

bind io_port io_port_checker u_chk (
  .clk(clk), .rstN(rstN), .ioStrobe(ioStrobe), .irBits(irBits), .acLow(acLow),
  .acLowWe(acLowWe), .skipReq(skipReq), .seqClear(seqClear), .inValid(inValid),
  .inReady(inReady), .outData(outData), .outValid(outValid), .outReady(outReady),
  .intEnable(intEnable)
);

// File: tb/io_port_bench.sv
module io_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ioStrobe = 1'b0;
  logic [5:0] irBits = '0;
  logic [7:0] acLow = '0;
  logic [7:0] acLowNew;
  logic       acLowWe, skipReq, seqClear;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] outData;
  logic       outValid;
  logic       outReady = 1'b0;
  logic       intEnable;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  int mFgi, mFgo, mIen, mInpr, mOutr;

  always #10 clk = ~clk;

  io_port u_io_port (
    .clk(clk), .rstN(rstN), .ioStrobe(ioStrobe), .irBits(irBits), .acLow(acLow),
    .acLowNew(acLowNew), .acLowWe(acLowWe), .skipReq(skipReq), .seqClear(seqClear),
    .inData(inData), .inValid(inValid), .inReady(inReady), .outData(outData),
    .outValid(outValid), .outReady(outReady), .intEnable(intEnable)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic compareAll();
    int eSkip;
    eSkip = ioStrobe && ((irBits[3] && mFgi == 1) || (irBits[2] && mFgo == 1));
    chk("R2 inReady", inReady, mFgi == 0);
    chk("R6 outValid", outValid, mFgo == 0);
    chk("R5 outData", outData, mOutr);
    chk("R8 intEnable", intEnable, mIen);
    chk("R4 acLowWe", acLowWe, ioStrobe && irBits[5]);
    if (ioStrobe && irBits[5]) chk("R3/R4 acLowNew", acLowNew, mInpr);
    chk("R7 skipReq", skipReq, eSkip);
    chk("R9 seqClear", seqClear, ioStrobe);
  endtask

  task automatic stepModel();
    int ld, acc;
    ld  = inValid && mFgi == 0;
    acc = outReady && mFgo == 0;
    if (ld) begin mInpr = inData; mFgi = 1; end
    else if (ioStrobe && irBits[5]) mFgi = 0;
    if (ioStrobe && irBits[4]) begin mOutr = acLow; mFgo = 0; end
    else if (acc) mFgo = 1;
    if (ioStrobe && irBits[0]) mIen = 0;
    else if (ioStrobe && irBits[1]) mIen = 1;
  endtask

  task automatic cyc(input bit s, input logic [5:0] ir, input logic [7:0] ac,
                     input bit iv, input logic [7:0] id, input bit orr);
    @(negedge clk);
    ioStrobe = s; irBits = ir; acLow = ac; inValid = iv; inData = id; outReady = orr;
    #2;
    compareAll();
    @(posedge clk);
    #1;
    stepModel();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    mFgi = 0; mFgo = 1; mIen = 0; mInpr = 0; mOutr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1 reset state
    chk("R1 inReady", inReady, 1);
    chk("R1 outValid", outValid, 0);
    chk("R1 outData", outData, 0);
    chk("R1 intEnable", intEnable, 0);
    // R7 skips with both flags in reset state: SKI no, SKO yes
    cyc(1, 6'b001000, 8'h00, 0, 8'h00, 0);
    cyc(1, 6'b000100, 8'h00, 0, 8'h00, 0);
    // R2 device load, R3 second offer ignored, R7 SKI now taken
    cyc(0, 6'b0, 8'h00, 1, 8'h41, 0);
    cyc(0, 6'b0, 8'h00, 1, 8'h5A, 0);
    cyc(1, 6'b001000, 8'h00, 1, 8'h77, 0);
    // R4 read returns first byte; R9 idle
    cyc(1, 6'b100000, 8'h00, 0, 8'h00, 0);
    cyc(0, 6'b0, 8'h00, 0, 8'h00, 0);
    // R4 read with simultaneous load: load wins
    cyc(1, 6'b100000, 8'h00, 1, 8'h33, 0);
    cyc(1, 6'b100000, 8'h00, 0, 8'h00, 0);
    // R5 write, device slow, then accept (R6)
    cyc(1, 6'b010000, 8'hC3, 0, 8'h00, 0);
    cyc(0, 6'b0, 8'h00, 0, 8'h00, 0);
    cyc(1, 6'b000100, 8'h00, 0, 8'h00, 1);
    // R6 write together with accept: write wins
    cyc(1, 6'b010000, 8'h11, 0, 8'h00, 0);
    cyc(1, 6'b010000, 8'h22, 0, 8'h00, 1);
    cyc(0, 6'b0, 8'h00, 0, 8'h00, 1);
    // R8 set, both, set, clear
    cyc(1, 6'b000010, 8'h00, 0, 8'h00, 0);
    cyc(0, 6'b0, 8'h00, 0, 8'h00, 0);
    cyc(1, 6'b000011, 8'h00, 0, 8'h00, 0);
    cyc(1, 6'b000010, 8'h00, 0, 8'h00, 0);
    cyc(1, 6'b000001, 8'h00, 0, 8'h00, 0);
    // mixed traffic, all requirements compared every cycle
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 3) == 0, 6'($urandom), 8'($urandom),
          ($urandom % 2) == 1, 8'($urandom), ($urandom % 3) == 0);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule